// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control logic wrapped around a 12-bit voltage converter that measures one channel at a time. Software sees five byte-wide registers on a simple write/read bus. It selects a channel, sets a start bit, and then polls that start bit (which doubles as a busy indication) or a sticky completion flag. When the conversion is done, software reads the result as a low byte and a high byte.

A cycle counter stands in for the analog conversion time. The conversion length is given as a duration in microseconds together with the clock rate in kHz, and the block turns these into a cycle count at elaboration. In the last cycle of that window the block samples a 12-bit value from an input port.

Three behaviours need care:

- A channel write made during a conversion is held back until that conversion ends.
- Any change of the system clock prescaler setting during a conversion cancels it.
- Choosing either of the two single-ended pin inputs automatically turns the partner pin into signal ground.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `data_valid` and `irq` are low, `conv_ch` is 0, `sgnd_pin1` is 1 and `sgnd_pin0` is 0.
- R2: Writing a byte with bit 0 set to the control register (address 0) while idle starts a conversion. Control bit 0 then reads 1 for exactly CLK_KHZ*CONV_US/1000 cycles and is then cleared by hardware.
- R3: On completion, the status register (address 1) bit 0 becomes 1. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R4: `irq` is high exactly when the status flag is 1 and the enable bit (control bit 1) is 1.
- R5: The result is the `sample_in` value present in the final cycle of the conversion. Address 3 returns bits 7:0 and address 4 returns bits 11:8 in its low nibble with zeros above. The result does not change until another conversion completes.
- R6: `data_valid` is low from the cycle after a start until the conversion completes. It is high from completion until the next start.
- R7: A start written while a conversion is busy is ignored and does not change when the conversion ends. A control write with bit 0 clear starts nothing.
- R8: A change of `prescale_sel` during a conversion aborts it. The busy bit clears on the next cycle, the flag is not set, the result is unchanged and `data_valid` stays low.
- R9: The channel register (address 2, bits 2:0) reads back the value last written. When idle, a write reaches `conv_ch` on the next cycle. During a conversion, `conv_ch` keeps the old channel and takes the newest written value when the conversion ends or aborts.
- R10: When `conv_ch` is 0, `sgnd_pin1` is 1. When `conv_ch` is 1, `sgnd_pin0` is 1. For any other channel both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| prescale_sel | input | 4 | Current system clock prescaler setting |
| sample_in | input | 12 | Converter output word |
| conv_ch | output | 3 | Channel applied to the converter input mux |
| data_valid | output | 1 | Result registers hold a completed conversion |
| irq | output | 1 | Conversion-complete interrupt request |
| sgnd_pin0 | output | 1 | Pin 0 switched to signal ground |
| sgnd_pin1 | output | 1 | Pin 1 switched to signal ground |

## Verification
The assertions rely on three assumptions about the inputs:

- `prescale_sel` changes only between clock edges, so a change seen while busy can be attributed to that conversion.
- A conversion starts only because of a bus write.
- The bus makes at most one access per cycle, so a channel write and a start never coincide.

The directed stimulus drives every input on the falling edge and issues one register access per cycle. It changes the prescaler only in the abort scenario and keeps it constant elsewhere.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int BUS_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_CHAN = 3'd2,
    A_RLO  = 3'd3,
    A_RHI  = 3'd4
  } reg_addr_e;

  localparam int B_START = 0;
  localparam int B_IEN   = 1;
  localparam int B_FLAG  = 0;

  localparam int SE_PIN0_CH = 0;
  localparam int SE_PIN1_CH = 1;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CYCLES = 2076,
  parameter int PRS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_go,
  input  logic [PRS_W-1:0] prescale_sel,
  output logic             busy,
  output logic             done,
  output logic             abort
);

  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic [PRS_W-1:0] prs_q;
  logic             prs_chg;
  logic             cnt_en;

  assign prs_chg = (prescale_sel != prs_q);
  assign abort   = busy_q & prs_chg;
  assign done    = busy_q & ~prs_chg & (cnt_q == LAST);
  assign busy    = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (abort || done) begin
      busy_d = 1'b0;
    end else if (start_go && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      prs_q  <= '0;
    end else begin
      busy_q <= busy_d;
      prs_q  <= prescale_sel;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_go,
  input  logic             done,
  input  logic [RES_W-1:0] sample_in,
  output logic [RES_W-1:0] result,
  output logic             valid
);

  logic [RES_W-1:0] res_q;
  logic             valid_q, valid_d;

  always_comb begin
    valid_d = valid_q;
    if (done)          valid_d = 1'b1;
    else if (start_go) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (done) res_q <= sample_in;
    end
  end

  assign result = res_q;
  assign valid  = valid_q;

endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chan_wr,
  input  logic [CH_W-1:0] chan_wdata,
  input  logic            busy,
  input  logic            end_evt,
  output logic [CH_W-1:0] chan_sel,
  output logic [CH_W-1:0] act_ch,
  output logic            sgnd0,
  output logic            sgnd1
);

  logic [CH_W-1:0] sel_q, act_q, act_d;
  logic            act_en;

  always_comb begin
    act_d  = act_q;
    act_en = 1'b0;
    if (chan_wr && (!busy || end_evt)) begin
      act_d  = chan_wdata;
      act_en = 1'b1;
    end else if (end_evt) begin
      act_d  = sel_q;
      act_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      act_q <= '0;
    end else begin
      if (chan_wr) sel_q <= chan_wdata;
      if (act_en)  act_q <= act_d;
    end
  end

  // Selecting one single-ended pin grounds its partner.
  assign sgnd1    = (act_q == CH_W'(SE_PIN0_CH));
  assign sgnd0    = (act_q == CH_W'(SE_PIN1_CH));
  assign chan_sel = sel_q;
  assign act_ch   = act_q;

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int RES_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic [RES_W-1:0]  result,
  output logic              start_go,
  output logic              chan_wr,
  output logic              ien,
  output logic              flag
);

  localparam int HI_W = RES_W - 8;

  logic ien_q, flag_q, flag_d;
  logic ctrl_wr, stat_clr;

  assign ctrl_wr  = bus_we && (bus_addr == A_CTRL);
  assign chan_wr  = bus_we && (bus_addr == A_CHAN);
  assign stat_clr = bus_we && (bus_addr == A_STAT) && bus_wdata[B_FLAG];
  assign start_go = ctrl_wr && bus_wdata[B_START] && !busy;

  always_comb begin
    flag_d = flag_q;
    if (done)          flag_d = 1'b1;
    else if (stat_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (ctrl_wr) ien_q <= bus_wdata[B_IEN];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_START] = busy;
        bus_rdata[B_IEN]   = ien_q;
      end
      A_STAT: bus_rdata[B_FLAG] = flag_q;
      A_CHAN: bus_rdata[CH_W-1:0] = chan_sel;
      A_RLO:  bus_rdata = result[7:0];
      A_RHI:  bus_rdata[HI_W-1:0] = result[RES_W-1:8];
      default: bus_rdata = '0;
    endcase
  end

  assign ien  = ien_q;
  assign flag = flag_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CLK_KHZ = 4000,
  parameter int CONV_US = 519,
  parameter int PRS_W   = 4,
  parameter int CH_W    = 3,
  parameter int RES_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [PRS_W-1:0]  prescale_sel,
  input  logic [RES_W-1:0]  sample_in,
  output logic [CH_W-1:0]   conv_ch,
  output logic              data_valid,
  output logic              irq,
  output logic              sgnd_pin0,
  output logic              sgnd_pin1
);

  localparam int CONV_CYC = (CLK_KHZ * CONV_US) / 1000;

  logic             busy_w, done_w, abort_w, start_w, chan_wr_w;
  logic             ien_w, flag_w;
  logic [CH_W-1:0]  chan_sel_w;
  logic [RES_W-1:0] result_w;

  adc_seq_timer #(.CYCLES(CONV_CYC), .PRS_W(PRS_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_go     (start_w),
    .prescale_sel (prescale_sel),
    .busy         (busy_w),
    .done         (done_w),
    .abort        (abort_w)
  );

  adc_seq_result #(.RES_W(RES_W)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_go  (start_w),
    .done      (done_w),
    .sample_in (sample_in),
    .result    (result_w),
    .valid     (data_valid)
  );

  adc_seq_chan #(.CH_W(CH_W)) u_chan (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_wr    (chan_wr_w),
    .chan_wdata (bus_wdata[CH_W-1:0]),
    .busy       (busy_w),
    .end_evt    (done_w | abort_w),
    .chan_sel   (chan_sel_w),
    .act_ch     (conv_ch),
    .sgnd0      (sgnd_pin0),
    .sgnd1      (sgnd_pin1)
  );

  adc_seq_regs #(.CH_W(CH_W), .RES_W(RES_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy_w),
    .done      (done_w),
    .chan_sel  (chan_sel_w),
    .result    (result_w),
    .start_go  (start_w),
    .chan_wr   (chan_wr_w),
    .ien       (ien_w),
    .flag      (flag_w)
  );

  assign irq = flag_w & ien_w;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int PRS_W = 4,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [PRS_W-1:0] prescale_sel,
  input logic [CH_W-1:0]  conv_ch,
  input logic             data_valid,
  input logic             irq,
  input logic             sgnd_pin0,
  input logic             sgnd_pin1,
  input logic             busy_w,
  input logic             flag_w
);

  AST_START_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_w) |-> $past(bus_we)); // R2

  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_w) |-> $fell(busy_w)); // R3

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_w); // R4

  AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $fell(busy_w)); // R5

  AST_INVALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> !data_valid); // R6

  AST_PRESCALE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !$stable(prescale_sel)) |=> !busy_w); // R8

  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && $past(busy_w)) |-> $stable(conv_ch)); // R9

  AST_ONE_GROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sgnd_pin0, sgnd_pin1})); // R10

endmodule

bind adc_seq_ctrl adc_seq_chk #(.PRS_W(PRS_W), .CH_W(CH_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_we       (bus_we),
  .prescale_sel (prescale_sel),
  .conv_ch      (conv_ch),
  .data_valid   (data_valid),
  .irq          (irq),
  .sgnd_pin0    (sgnd_pin0),
  .sgnd_pin1    (sgnd_pin1),
  .busy_w       (busy_w),
  .flag_w       (flag_w)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ    = 100;
  localparam int CONV_US    = 519;
  localparam int EXP_CYC    = 51;   // 100 kHz * 519 us
  localparam int WDOG       = 100000;

  logic        clk, rst_n, bus_we;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [3:0]  prescale_sel;
  logic [11:0] sample_in;
  logic [2:0]  conv_ch;
  logic        data_valid, irq, sgnd_pin0, sgnd_pin1;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  adc_seq_ctrl #(.CLK_KHZ(CLK_KHZ), .CONV_US(CONV_US)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prescale_sel(prescale_sel),
    .sample_in(sample_in), .conv_ch(conv_ch), .data_valid(data_valid),
    .irq(irq), .sgnd_pin0(sgnd_pin0), .sgnd_pin1(sgnd_pin1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Returns number of cycles the busy bit reads 1.
  task automatic count_busy(output int n);
    logic [7:0] v;
    n = 0;
    for (int k = 0; k < EXP_CYC + 10; k++) begin
      rd(3'd0, v);
      if (!v[0]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], v);
      check("R1 reg reset", v, 8'h00);
    end
    check("R1 data_valid", data_valid, 1'b0);
    check("R1 irq", irq, 1'b0);
    check("R1 conv_ch", conv_ch, 3'd0);
    check("R1 sgnd_pin1", sgnd_pin1, 1'b1);
    check("R1 sgnd_pin0", sgnd_pin0, 1'b0);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    int n;
    wr(3'd2, 8'h02);
    check("R9 idle channel applied", conv_ch, 3'd2);
    check("R10 pin0 released", sgnd_pin0, 1'b0);
    check("R10 pin1 released", sgnd_pin1, 1'b0);
    wr(3'd0, 8'h02);
    rd(3'd0, v);
    check("R7 start 0 no effect", v, 8'h02);
    sample_in = 12'h123;
    wr(3'd0, 8'h03);
    check("R6 valid low while busy", data_valid, 1'b0);
    count_busy(n);
    check("R2 busy length", n, EXP_CYC);
    rd(3'd1, v);
    check("R3 flag set", v, 8'h01);
    check("R4 irq high", irq, 1'b1);
    check("R6 valid after done", data_valid, 1'b1);
    rd(3'd3, v);
    check("R5 low byte", v, 8'h23);
    rd(3'd4, v);
    check("R5 high byte", v, 8'h01);
  endtask

  task automatic t_flag;
    logic [7:0] v;
    wr(3'd1, 8'h00);
    rd(3'd1, v);
    check("R3 write 0 keeps flag", v, 8'h01);
    wr(3'd1, 8'h01);
    rd(3'd1, v);
    check("R3 write 1 clears flag", v, 8'h00);
    check("R4 irq low", irq, 1'b0);
  endtask

  task automatic t_defer;
    logic [7:0] v;
    int n;
    sample_in = 12'h555;
    wr(3'd0, 8'h03);
    n = 0;
    for (int k = 0; k < EXP_CYC + 10; k++) begin
      rd(3'd0, v);
      if (!v[0]) break;
      n++;
      if (k == 10) begin
        check("R9 old channel kept", conv_ch, 3'd2);
        check("R6 valid low mid conversion", data_valid, 1'b0);
        rd(3'd2, v);
        check("R9 readback newest", v, 8'h01);
      end
      bus_we = 1'b0;
      if (k == 5)  begin bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h01; end
      if (k == 20) begin bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h03; end
      if (k == 30) sample_in = 12'hABC;
      @(negedge clk);
    end
    bus_we = 1'b0;
    check("R7 restart ignored", n, EXP_CYC);
    check("R9 channel after end", conv_ch, 3'd1);
    check("R10 pin0 grounded", sgnd_pin0, 1'b1);
    check("R10 pin1 free", sgnd_pin1, 1'b0);
    sample_in = 12'h777;
    @(negedge clk);
    rd(3'd3, v);
    check("R5 final-cycle low", v, 8'hBC);
    rd(3'd4, v);
    check("R5 final-cycle high", v, 8'h0A);
    wr(3'd1, 8'h01);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    wr(3'd2, 8'h00);
    check("R10 pin1 grounded", sgnd_pin1, 1'b1);
    wr(3'd0, 8'h03);
    repeat (4) @(negedge clk);
    prescale_sel = 4'h3;
    @(negedge clk);
    rd(3'd0, v);
    check("R8 busy cleared", v[0], 1'b0);
    rd(3'd1, v);
    check("R8 no flag", v, 8'h00);
    check("R8 valid stays low", data_valid, 1'b0);
    rd(3'd3, v);
    check("R8 result unchanged", v, 8'hBC);
    repeat (EXP_CYC) @(negedge clk);
    rd(3'd1, v);
    check("R8 flag never set", v, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 3'd0; bus_wdata = 8'h00;
    prescale_sel = 4'h0; sample_in = 12'h000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_flag();
    t_defer();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule